// File: doc/BRIEF.md
# Posted-Transfer Fault Recorder

This block watches posted transfers on a system bus and records the first error that one of them produces. Each transfer announces itself with a start strobe that carries its address, a size code, a read/write flag and a supervisor flag. A transfer ends when it gets a normal acknowledge or an error acknowledge. A separate pulse reports an error that the bus raised after the most recent transfer had already finished. While a write is outstanding, a timer counts clock cycles. If no acknowledge arrives within a fixed number of cycles, the write is declared timed out.

The first error fills a 32-bit status word and a fault address register that software reads. The recorded details are the class of the error, the size code, the supervisor flag and the read flag, and the address register is marked valid. Any later error only raises a multiple-error flag, so the first error's details stay intact for the handler. An interrupt line stays high while an error is recorded. A software write to the status word clears the record so that it can take the next error.

Top module: `afr_fault_recorder`

## Requirements
- R1: After reset the status word reads 0x00800000, the fault address reads 0 and the interrupt is low.
- R2: Status bit 31 is set exactly when at least one of bits 30, 29, 28 is set, and the interrupt output equals bit 31.
- R3: An error acknowledge received while a write is outstanding sets bit 28. If no error was recorded, it also fills bits 27:25 with the size code, sets bit 24 to the supervisor flag, clears bit 18, sets bit 17 and loads the fault address with the transfer address. All of this is visible after the clock edge that samples the error acknowledge.
- R4: An error acknowledge received while a read is outstanding ends the read and records nothing.
- R5: A write that receives no acknowledge sets bit 29 at the TIMEOUT_CYCLES-th clock edge after the edge that sampled its start strobe, and not before. An acknowledge sampled one edge earlier prevents the timeout. An outstanding read never times out.
- R6: A late-error pulse sets bit 30 and captures the details of the most recently started transfer, with bit 18 set when that transfer was a read.
- R7: While an error is recorded, a further error sets bit 19 and changes no other status bit and no bit of the fault address.
- R8: When two error events arrive on the same edge and nothing is recorded, both class bits are set, bit 19 is set, and the details are taken from the current transfer.
- R9: A software write to the status word clears bits 31:24 and 19:17, and the fault address keeps its value. If an error event arrives on the same edge, it is recorded as a first error after the clear.
- R10: Status bits 23:20 always read 0x8, and bits 16:0 always read 0.
- R11: A write that receives a normal acknowledge ends without any error bit being set, and it does not time out later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txnStart | input | 1 | Start strobe of a transfer |
| txnAddr | input | ADDR_W | Address of the starting transfer |
| txnSize | input | 3 | Size code of the starting transfer |
| txnRead | input | 1 | 1 for a read, 0 for a write |
| txnSuper | input | 1 | Issuer was in supervisor mode |
| busAck | input | 1 | Normal acknowledge of the outstanding transfer |
| busErrAck | input | 1 | Error acknowledge of the outstanding transfer |
| lateErr | input | 1 | Error reported after the last transfer finished |
| statusWrite | input | 1 | Software write to the status word (clears it) |
| statusWord | output | 32 | Fault status word |
| faultAddr | output | ADDR_W | Address of the first recorded fault |
| faultIrq | output | 1 | Interrupt, high while an error is recorded |

## Verification
The error classes are exercised one at a time: an error acknowledge on a write, an error acknowledge on a read, a silent write, and a late pulse after a completed read. These show whether the classification depends on direction and whether the captured read flag is taken from the right transfer. The timeout is approached from both sides of its edge: one check looks just before the limit and one at it, and another acknowledges one edge before the limit. Together they pin down the exact cycle count. A long read that stays pending confirms that only writes are timed. An error on top of a recorded one, two errors on the same edge, and a clear that coincides with an error separate the first-error capture from the multiple-error flag.

// File: rtl/afr_pkg.sv
package afr_pkg;

  // Outstanding-transfer state kept by the control side.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WR_PEND = 2'd1,
    ST_RD_PEND = 2'd2
  } pendState_t;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic loadTxn;   // latch details of a new transfer
    logic beEvent;   // error acknowledge on an outstanding write
    logic toEvent;   // outstanding write ran out of time
    logic leEvent;   // error reported after the transfer
    logic clearAll;  // software write to the status word
  } ctrlStrobes_t;

  localparam int SIZE_W = 3;
  localparam logic [3:0] RESV_PATTERN = 4'h8;

endpackage

// File: rtl/afr_ctrl.sv
module afr_ctrl
  import afr_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 320  // must be 2 or more
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         txnStart,
  input  logic         txnRead,
  input  logic         busAck,
  input  logic         busErrAck,
  input  logic         lateErr,
  input  logic         statusWrite,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  pendState_t stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic anyAck;
  logic timeUp;

  assign anyAck = busAck | busErrAck;
  assign timeUp = (cntQ == CNT_LAST);

  always_comb begin
    strobes.loadTxn  = txnStart;
    strobes.beEvent  = (stateQ == ST_WR_PEND) && busErrAck;
    strobes.toEvent  = (stateQ == ST_WR_PEND) && !anyAck && timeUp;
    strobes.leEvent  = lateErr;
    strobes.clearAll = statusWrite;
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_WR_PEND: begin
        if (anyAck || timeUp) begin
          stateD = ST_IDLE;
          cntD   = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_RD_PEND: begin
        if (anyAck) stateD = ST_IDLE;
      end
      default: ;
    endcase
    if (txnStart) begin
      stateD = txnRead ? ST_RD_PEND : ST_WR_PEND;
      cntD   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cntQ <= CNT_LAST);  // R5

  AST_TO_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.toEvent && !txnStart) |=> (stateQ == ST_IDLE));  // R5

  AST_READ_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_RD_PEND) |-> (cntQ == '0));  // R5

endmodule

// File: rtl/afr_datapath.sv
module afr_datapath
  import afr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [SIZE_W-1:0] txnSize,
  input  logic              txnRead,
  input  logic              txnSuper,
  output logic [31:0]       statusWord,
  output logic [ADDR_W-1:0] faultAddr
);

  // Details of the most recently started transfer.
  logic [ADDR_W-1:0] curAddrQ;
  logic [SIZE_W-1:0] curSizeQ;
  logic              curReadQ;
  logic              curSuperQ;

  // Recorded fault state.
  logic              errSumQ;
  logic              leQ, toQ, beQ;
  logic [SIZE_W-1:0] capSizeQ;
  logic              capSuperQ;
  logic              capReadQ;
  logic              multiQ;
  logic              validQ;
  logic [ADDR_W-1:0] faultAddrQ;

  logic anyEvt;
  logic twoEvt;
  logic heldAfterClear;

  assign anyEvt = strobes.beEvent | strobes.toEvent | strobes.leEvent;
  assign twoEvt = (strobes.beEvent & strobes.toEvent) |
                  (strobes.beEvent & strobes.leEvent) |
                  (strobes.toEvent & strobes.leEvent);
  assign heldAfterClear = !strobes.clearAll && (leQ | toQ | beQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curAddrQ  <= '0;
      curSizeQ  <= '0;
      curReadQ  <= 1'b0;
      curSuperQ <= 1'b0;
    end else if (strobes.loadTxn) begin
      curAddrQ  <= txnAddr;
      curSizeQ  <= txnSize;
      curReadQ  <= txnRead;
      curSuperQ <= txnSuper;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      errSumQ    <= 1'b0;
      leQ        <= 1'b0;
      toQ        <= 1'b0;
      beQ        <= 1'b0;
      capSizeQ   <= '0;
      capSuperQ  <= 1'b0;
      capReadQ   <= 1'b0;
      multiQ     <= 1'b0;
      validQ     <= 1'b0;
      faultAddrQ <= '0;
    end else begin
      if (strobes.clearAll) begin
        errSumQ   <= 1'b0;
        leQ       <= 1'b0;
        toQ       <= 1'b0;
        beQ       <= 1'b0;
        capSizeQ  <= '0;
        capSuperQ <= 1'b0;
        capReadQ  <= 1'b0;
        multiQ    <= 1'b0;
        validQ    <= 1'b0;
      end
      if (anyEvt) begin
        if (heldAfterClear) begin
          multiQ <= 1'b1;
        end else begin
          errSumQ    <= 1'b1;
          leQ        <= strobes.leEvent;
          toQ        <= strobes.toEvent;
          beQ        <= strobes.beEvent;
          capSizeQ   <= curSizeQ;
          capSuperQ  <= curSuperQ;
          capReadQ   <= curReadQ;
          multiQ     <= twoEvt;
          validQ     <= 1'b1;
          faultAddrQ <= curAddrQ;
        end
      end
    end
  end

  assign statusWord = {errSumQ, leQ, toQ, beQ, capSizeQ, capSuperQ,
                       RESV_PATTERN, multiQ, capReadQ, validQ, 17'd0};
  assign faultAddr  = faultAddrQ;

  AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    errSumQ == (leQ | toQ | beQ));  // R2

  AST_MULTI_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    multiQ |-> validQ);  // R7

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (validQ && !strobes.clearAll) |=> $stable(faultAddrQ));  // R7

  AST_CLASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (errSumQ && !strobes.clearAll) |=> $stable({leQ, toQ, beQ, capSizeQ}));  // R7

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clearAll && !anyEvt) |=> (!errSumQ && !validQ && !multiQ));  // R9

endmodule

// File: rtl/afr_fault_recorder.sv
module afr_fault_recorder
  import afr_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int TIMEOUT_CYCLES = 320  // 12.8 us at 25 MHz
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txnStart,
  input  logic [ADDR_W-1:0] txnAddr,
  input  logic [2:0]        txnSize,
  input  logic              txnRead,
  input  logic              txnSuper,
  input  logic              busAck,
  input  logic              busErrAck,
  input  logic              lateErr,
  input  logic              statusWrite,
  output logic [31:0]       statusWord,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              faultIrq
);

  ctrlStrobes_t strobes;

  afr_ctrl #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .txnStart   (txnStart),
    .txnRead    (txnRead),
    .busAck     (busAck),
    .busErrAck  (busErrAck),
    .lateErr    (lateErr),
    .statusWrite(statusWrite),
    .strobes    (strobes)
  );

  afr_datapath #(
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .txnAddr   (txnAddr),
    .txnSize   (txnSize),
    .txnRead   (txnRead),
    .txnSuper  (txnSuper),
    .statusWord(statusWord),
    .faultAddr (faultAddr)
  );

  assign faultIrq = statusWord[31];

endmodule

// File: tb/afr_fault_recorder_tb_top.sv
module afr_fault_recorder_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_LIMIT   = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txnStart = 1'b0;
  logic [31:0] txnAddr = '0;
  logic [2:0]  txnSize = '0;
  logic        txnRead = 1'b0;
  logic        txnSuper = 1'b0;
  logic        busAck = 1'b0;
  logic        busErrAck = 1'b0;
  logic        lateErr = 1'b0;
  logic        statusWrite = 1'b0;
  logic [31:0] statusWord;
  logic [31:0] faultAddr;
  logic        faultIrq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  afr_fault_recorder #(
    .ADDR_W(32),
    .TIMEOUT_CYCLES(TB_LIMIT)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .txnStart   (txnStart),
    .txnAddr    (txnAddr),
    .txnSize    (txnSize),
    .txnRead    (txnRead),
    .txnSuper   (txnSuper),
    .busAck     (busAck),
    .busErrAck  (busErrAck),
    .lateErr    (lateErr),
    .statusWrite(statusWrite),
    .statusWord (statusWord),
    .faultAddr  (faultAddr),
    .faultIrq   (faultIrq)
  );

  function automatic logic [31:0] mkStatus(input logic le, input logic to,
      input logic be, input logic [2:0] sz, input logic sup, input logic me,
      input logic rd, input logic fav);
    return {le | to | be, le, to, be, sz, sup, 4'h8, me, rd, fav, 17'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic doStart(input logic [31:0] a, input logic [2:0] s, input logic rd, input logic sup);
    @(negedge clk);
    txnStart = 1'b1; txnAddr = a; txnSize = s; txnRead = rd; txnSuper = sup;
    @(negedge clk);
    txnStart = 1'b0;
  endtask

  task automatic drivePulse(input logic ack, input logic eack, input logic late, input logic clr);
    @(negedge clk);
    busAck = ack; busErrAck = eack; lateErr = late; statusWrite = clr;
    @(negedge clk);
    busAck = 1'b0; busErrAck = 1'b0; lateErr = 1'b0; statusWrite = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 status", statusWord, 32'h0080_0000);
    chk("R1 addr", faultAddr, 32'h0);
    chk("R1 irq", {31'd0, faultIrq}, 32'd0);
    chk("R10 const", statusWord & 32'h00F1_FFFF, 32'h0080_0000);
  endtask

  task automatic testWriteErrAck();
    drivePulse(0, 0, 0, 1);
    doStart(32'h1234_5670, 3'd3, 1'b0, 1'b1);
    drivePulse(0, 1, 0, 0);
    chk("R3 status", statusWord, mkStatus(0, 0, 1, 3'd3, 1, 0, 0, 1));
    chk("R3 addr", faultAddr, 32'h1234_5670);
    chk("R2 irq", {31'd0, faultIrq}, 32'd1);
  endtask

  task automatic testMulti();
    doStart(32'hCAFE_0000, 3'd1, 1'b0, 1'b0);
    drivePulse(0, 1, 0, 0);
    chk("R7 status", statusWord, mkStatus(0, 0, 1, 3'd3, 1, 1, 0, 1));
    chk("R7 addr", faultAddr, 32'h1234_5670);
  endtask

  task automatic testClear();
    drivePulse(0, 0, 0, 1);
    chk("R9 status", statusWord, mkStatus(0, 0, 0, 3'd0, 0, 0, 0, 0));
    chk("R9 addr kept", faultAddr, 32'h1234_5670);
    chk("R2 irq low", {31'd0, faultIrq}, 32'd0);
  endtask

  task automatic testReadErrAck();
    drivePulse(0, 0, 0, 1);
    doStart(32'h0000_4000, 3'd2, 1'b1, 1'b0);
    drivePulse(0, 1, 0, 0);
    chk("R4 status", statusWord, mkStatus(0, 0, 0, 3'd0, 0, 0, 0, 0));
  endtask

  task automatic testTimeout();
    drivePulse(0, 0, 0, 1);
    doStart(32'h8000_0010, 3'd2, 1'b0, 1'b0);
    repeat (TB_LIMIT - 1) @(negedge clk);
    chk("R5 before limit", statusWord, mkStatus(0, 0, 0, 3'd0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R5 at limit", statusWord, mkStatus(0, 1, 0, 3'd2, 0, 0, 0, 1));
    chk("R5 addr", faultAddr, 32'h8000_0010);
  endtask

  task automatic testAckInTime();
    drivePulse(0, 0, 0, 1);
    doStart(32'h8000_0020, 3'd1, 1'b0, 1'b1);
    repeat (TB_LIMIT - 3) @(negedge clk);
    drivePulse(1, 0, 0, 0);
    repeat (3 * TB_LIMIT) @(negedge clk);
    chk("R5 R11 acked write", statusWord, mkStatus(0, 0, 0, 3'd0, 0, 0, 0, 0));
  endtask

  task automatic testReadNoTimeout();
    drivePulse(0, 0, 0, 1);
    doStart(32'h8000_0030, 3'd1, 1'b1, 1'b0);
    repeat (3 * TB_LIMIT) @(negedge clk);
    chk("R5 read pending", statusWord, mkStatus(0, 0, 0, 3'd0, 0, 0, 0, 0));
    drivePulse(1, 0, 0, 0);
  endtask

  task automatic testLateErr();
    drivePulse(0, 0, 0, 1);
    doStart(32'h0BAD_0040, 3'd2, 1'b1, 1'b0);
    drivePulse(1, 0, 0, 0);
    chk("R11 no error", statusWord, mkStatus(0, 0, 0, 3'd0, 0, 0, 0, 0));
    drivePulse(0, 0, 1, 0);
    chk("R6 status", statusWord, mkStatus(1, 0, 0, 3'd2, 0, 0, 1, 1));
    chk("R6 addr", faultAddr, 32'h0BAD_0040);
  endtask

  task automatic testSimultaneous();
    drivePulse(0, 0, 0, 1);
    doStart(32'h0000_0D00, 3'd4, 1'b0, 1'b1);
    drivePulse(0, 1, 1, 0);
    chk("R8 status", statusWord, mkStatus(1, 0, 1, 3'd4, 1, 1, 0, 1));
    chk("R8 addr", faultAddr, 32'h0000_0D00);
  endtask

  task automatic testClearWithEvent();
    doStart(32'h0000_0E00, 3'd5, 1'b1, 1'b1);
    drivePulse(1, 0, 0, 0);
    drivePulse(0, 0, 1, 1);
    chk("R9 clear+event", statusWord, mkStatus(1, 0, 0, 3'd5, 1, 0, 1, 1));
    chk("R9 clear+event addr", faultAddr, 32'h0000_0E00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testWriteErrAck();
    testMulti();
    testClear();
    testReadErrAck();
    testTimeout();
    testAckInTime();
    testReadNoTimeout();
    testLateErr();
    testSimultaneous();
    testClearWithEvent();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule